// File: doc/BRIEF.md
# Run-length configuration bit expander

The block turns a stream of compressed code bytes into a serial stream of configuration bits. Code bytes enter through a valid/ready byte port. Each accepted byte expands into a run of identical bits. Most codes also append one closing bit of the opposite value. The bits leave one at a time through a valid/ready port, and a serial shifter further down the line consumes them.

There are four code ranges, set by the parameter `MAX_ONES` (default 226):

- The low range gives runs of ones closed by a zero.
- One code gives a full-length run of ones with no closing bit.
- The upper range gives runs of zeros closed by a one.
- The all-ones code gives a single one.

Code zero produces nothing. While an expansion is in progress the block refuses new bytes, so the downstream consumer paces the whole stream through its ready signal.

Top module: `rlx_expander`

## Requirements
- R1: A code n with 1 <= n <= MAX_ONES (226 by default) produces n one-bits followed by a single zero-bit.
- R2: Code MAX_ONES+1 (227) produces exactly MAX_ONES one-bits and no closing zero.
- R3: A code n with MAX_ONES+2 <= n <= 254 produces n-(MAX_ONES+2) zero-bits followed by a single one-bit. Code 228 therefore produces just one one-bit.
- R4: Code 255 (all ones) produces exactly one one-bit.
- R5: Code 0 produces no bits. It is consumed in one cycle, and in the cycle after acceptance `in_ready` is high and `out_valid` is low.
- R6: `in_ready` is low whenever `out_valid` is high. A new code is taken only after the last bit of the previous expansion has been handed over (`out_valid && out_ready`).
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` keeps its value.
- R8: A synchronous active-high `rst` discards any expansion in progress. In the cycle after reset, `out_valid` is low and `in_ready` is high.
- R9: When a code other than 0 is accepted, `out_valid` rises in the next cycle. Bits leave in expansion order, with the run first and the closing bit last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Code byte on `in_code` is offered |
| in_ready | output | 1 | Block accepts a code this cycle |
| in_code | input | CODE_W | Compressed code byte |
| out_valid | output | 1 | `out_bit` holds a configuration bit |
| out_ready | input | 1 | Downstream takes the bit this cycle |
| out_bit | output | 1 | Current configuration bit |

## Verification
The hardest situation to reach from the ports is a code offered continuously while a long expansion stalls part-way through. That is where an early `in_ready` or a lost count would show. The bench sweeps every one of the 256 codes back to back, with `in_valid` held high throughout. It throttles `out_ready` with a pseudo-random pattern, so every run length up to 226 is drained through repeated stalls. The received stream is compared bit by bit with an arithmetic model of the four code ranges. Directed cases then cover a long stall, code zero on an idle block, and a reset in the middle of a run.

// File: rtl/rlx_pkg.sv
package rlx_pkg;

   // Class of a code byte, resolved by the decoder
   typedef enum logic [2:0] {
      CLS_EMPTY      = 3'd0,
      CLS_ONES_TERM  = 3'd1,
      CLS_ONES_FULL  = 3'd2,
      CLS_ZEROS_TERM = 3'd3,
      CLS_SINGLE_ONE = 3'd4
   } rlx_cls_e;

   function automatic int rlx_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rlx_code_decode.sv
module rlx_code_decode
   import rlx_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int MAX_ONES = 226,
   parameter int CNT_W    = 8
) (
   input  logic [CODE_W-1:0] code,
   output rlx_cls_e          cls,
   output logic [CNT_W-1:0]  run_len,
   output logic              run_val,
   output logic              run_term
);
   localparam logic [CODE_W-1:0] C_ONES_LO = CODE_W'(1);
   localparam logic [CODE_W-1:0] C_ONES_HI = CODE_W'(MAX_ONES);
   localparam logic [CODE_W-1:0] C_FULL    = CODE_W'(MAX_ONES + 1);
   localparam logic [CODE_W-1:0] C_ZBASE   = CODE_W'(MAX_ONES + 2);
   localparam logic [CODE_W-1:0] C_TOP     = {CODE_W{1'b1}};

   initial begin
      if (CODE_W < 2)
         $error("rlx_code_decode: CODE_W must be at least 2");
      if (MAX_ONES < 1 || MAX_ONES + 2 > (1 << CODE_W) - 1)
         $error("rlx_code_decode: MAX_ONES leaves no room for the zero-run range");
   end

   logic [CODE_W-1:0] zero_off;
   assign zero_off = code - C_ZBASE;

   always_comb begin
      if (code == '0)
         cls = CLS_EMPTY;
      else if (code >= C_ONES_LO && code <= C_ONES_HI)
         cls = CLS_ONES_TERM;
      else if (code == C_FULL)
         cls = CLS_ONES_FULL;
      else if (code == C_TOP)
         cls = CLS_SINGLE_ONE;
      else
         cls = CLS_ZEROS_TERM;
   end

   always_comb begin
      run_len  = '0;
      run_val  = 1'b0;
      run_term = 1'b0;
      unique case (cls)
         CLS_ONES_TERM: begin
            run_len  = CNT_W'(code);
            run_val  = 1'b1;
            run_term = 1'b1;
         end
         CLS_ONES_FULL: begin
            run_len  = CNT_W'(MAX_ONES);
            run_val  = 1'b1;
         end
         CLS_ZEROS_TERM: begin
            run_len  = CNT_W'(zero_off);
            run_val  = 1'b0;
            run_term = 1'b1;
         end
         CLS_SINGLE_ONE: begin
            run_len  = CNT_W'(1);
            run_val  = 1'b1;
         end
         default: begin
            run_len  = '0;
         end
      endcase
   end

endmodule

// File: rtl/rlx_run_engine.sv
module rlx_run_engine #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] ld_len,
   input  logic             ld_val,
   input  logic             ld_term,
   input  logic             out_ready,
   output logic             out_valid,
   output logic             out_bit,
   output logic             last_bit
);
   initial begin
      if (CNT_W < 1)
         $error("rlx_run_engine: CNT_W must be positive");
   end

   logic [CNT_W-1:0] remain_q;
   logic             level_q;
   logic             close_q;
   logic             run_live;
   logic             fire;

   assign run_live  = (remain_q != '0);
   assign out_valid = run_live || close_q;
   assign out_bit   = run_live ? level_q : ~level_q;
   assign last_bit  = out_valid &&
                      ((remain_q == CNT_W'(1) && !close_q) || (!run_live && close_q));
   assign fire      = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         remain_q <= '0;
         level_q  <= 1'b0;
         close_q  <= 1'b0;
      end else if (load) begin
         remain_q <= ld_len;
         level_q  <= ld_val;
         close_q  <= ld_term;
      end else if (fire) begin
         if (run_live)
            remain_q <= remain_q - CNT_W'(1);
         else
            close_q  <= 1'b0;
      end
   end

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_bit)) else $error("hold"); // R7

   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> !out_valid) else $error("reset"); // R8

   AST_LAST_DRAINS: assert property (@(posedge clk) disable iff (rst)
      last_bit && out_ready && !load |=> !out_valid) else $error("drain"); // R9

endmodule

// File: rtl/rlx_expander.sv
module rlx_expander
   import rlx_pkg::*;
#(
   parameter int CODE_W       = 8,
   parameter int MAX_ONES     = 226,
   parameter bit LAST_OVERLAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CODE_W-1:0] in_code,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_bit
);
   localparam int ZRUN_MAX = (1 << CODE_W) - 2 - (MAX_ONES + 2);
   localparam int LEN_MAX  = rlx_max(MAX_ONES, ZRUN_MAX);
   localparam int CNT_W    = $clog2(LEN_MAX + 1);

   initial begin
      if (ZRUN_MAX < 0)
         $error("rlx_expander: code width too small for MAX_ONES");
   end

   rlx_cls_e         cls;
   logic [CNT_W-1:0] dec_len;
   logic             dec_val;
   logic             dec_term;
   logic             last_bit;
   logic             take;

   rlx_code_decode #(
      .CODE_W   (CODE_W),
      .MAX_ONES (MAX_ONES),
      .CNT_W    (CNT_W)
   ) i_decode (
      .code     (in_code),
      .cls      (cls),
      .run_len  (dec_len),
      .run_val  (dec_val),
      .run_term (dec_term)
   );

   generate
      if (LAST_OVERLAP) begin : g_overlap
         assign in_ready = !out_valid || (out_ready && last_bit);
      end else begin : g_idle_only
         assign in_ready = !out_valid;
      end
   endgenerate

   assign take = in_valid && in_ready;

   rlx_run_engine #(
      .CNT_W (CNT_W)
   ) i_engine (
      .clk       (clk),
      .rst       (rst),
      .load      (take),
      .ld_len    (dec_len),
      .ld_val    (dec_val),
      .ld_term   (dec_term),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_bit   (out_bit),
      .last_bit  (last_bit)
   );

   AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
      take |-> !out_valid || (LAST_OVERLAP && out_ready && last_bit)) else $error("busy"); // R6

   AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (rst)
      take && cls == CLS_EMPTY |=> !out_valid && in_ready) else $error("empty"); // R5

   AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (rst)
      take && cls != CLS_EMPTY |=> out_valid) else $error("load"); // R9

   AST_RESET_READY: assert property (@(posedge clk)
      rst |=> in_ready) else $error("rdy"); // R8

endmodule

// File: tb/test_rlx_expander.sv
module test_rlx_expander;
   localparam int MAXO  = 226;
   localparam int NCODE = 262;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_code = '0;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic       out_bit;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   rlx_expander i_rlx_expander (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_code(in_code), .out_valid(out_valid), .out_ready(out_ready),
      .out_bit(out_bit)
   );

   function automatic int code_at(input int i);
      if (i < 256) return i;
      case (i)
         256: return 227;
         257: return 255;
         258: return 228;
         259: return 0;
         260: return 1;
         default: return 254;
      endcase
   endfunction

   // expected number of bits for a code
   function automatic int exp_len(input int c);
      if (c == 0) return 0;
      if (c <= MAXO) return c + 1;
      if (c == MAXO + 1) return MAXO;
      if (c == 255) return 1;
      return c - (MAXO + 2) + 1;
   endfunction

   function automatic logic exp_bit(input int c, input int p);
      if (c <= MAXO) return (p < c) ? 1'b1 : 1'b0;
      if (c == MAXO + 1 || c == 255) return 1'b1;
      return (p < c - (MAXO + 2)) ? 1'b0 : 1'b1;
   endfunction

   function automatic string req_of(input int c);
      if (c <= MAXO) return "R1";
      if (c == MAXO + 1) return "R2";
      if (c == 255) return "R4";
      return "R3";
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   initial begin
      int  in_idx = 0;
      int  e_idx = 0;
      int  e_pos = 0;
      int  cyc = 0;
      logic [15:0] lfsr = 16'hACE1;
      logic in_fire;
      logic out_fire;
      logic got;

      // R8: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #5;
      check("R8 out_valid after reset", out_valid, 0);
      check("R8 in_ready after reset", in_ready, 1);

      // R5: code 0 on idle block
      @(negedge clk);
      in_valid = 1'b1; in_code = 8'd0;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      #5;
      check("R5 out_valid after code 0", out_valid, 0);
      check("R5 in_ready after code 0", in_ready, 1);

      // R7/R9/R6: code 5 with long stall, next code offered throughout
      @(negedge clk);
      in_valid = 1'b1; in_code = 8'd5; out_ready = 1'b0;
      @(posedge clk);
      @(negedge clk);
      in_code = 8'd3;
      #5;
      check("R9 out_valid after accept", out_valid, 1);
      for (int k = 0; k < 10; k++) begin
         @(posedge clk);
         #5;
         check("R7 out_valid during stall", out_valid, 1);
         check("R7 out_bit during stall", out_bit, 1);
         check("R6 in_ready low while busy", in_ready, 0);
      end

      // R8: reset mid-run, then drain nothing
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      out_ready = 1'b0;
      #5;
      check("R8 run discarded", out_valid, 0);
      check("R8 in_ready after mid-run reset", in_ready, 1);

      // Sweep of all codes under pseudo-random backpressure
      while (e_idx < NCODE && cyc < 150000) begin
         @(negedge clk);
         in_valid  = (in_idx < NCODE);
         in_code   = 8'(code_at((in_idx < NCODE) ? in_idx : 0));
         lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = (lfsr[1:0] != 2'b00);
         #5;
         in_fire  = in_valid && in_ready;
         out_fire = out_valid && out_ready;
         got      = out_bit;
         if (in_ready && out_valid)
            check("R6 ready while valid", 1, 0);
         @(posedge clk);
         cyc++;
         if (in_fire) in_idx++;
         while (e_idx < NCODE && exp_len(code_at(e_idx)) == 0) e_idx++;
         if (out_fire) begin
            if (e_idx >= NCODE) begin
               check("R9 extra bit", 1, 0);
            end else begin
               check(req_of(code_at(e_idx)), got, exp_bit(code_at(e_idx), e_pos));
               e_pos++;
               if (e_pos == exp_len(code_at(e_idx))) begin
                  e_pos = 0;
                  e_idx++;
               end
            end
         end
         while (e_idx < NCODE && exp_len(code_at(e_idx)) == 0 && in_idx > e_idx) e_idx++;
      end
      if (cyc >= 150000) check("watchdog", 1, 0);
      check("R9 all codes expanded", e_idx, NCODE);

      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
      repeat (3) @(posedge clk);
      #5;
      check("R9 idle after stream", out_valid, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule